// File: doc/BRIEF.md
# Watchdog Timer with Keyed Service Sequence

This block is a supervisory timer that guards a processor against runaway software. A counter advances on one of four candidate count enables. If software fails to feed it within the configured period, the block raises a system reset request. The request stays high until the block's own reset arrives. A two-bit cause output shows whether the request came from a plain timeout or from a service attempt made too early.

Software sets the watchdog up through an 8-bit control register, and only the first write after reset is accepted. The configuration picks a short or long timeout class and one of three power-of-two lengths, or turns the timer off. It also picks the count source and can enable windowed servicing. Two more bits decide whether counting carries on while the system is in stop mode or in debug mode. When those bits are clear, the counter is cleared and held in that mode rather than paused. Feeding is done through a separate 8-bit service register that must receive a two-byte key.

Top module: `wdog_core`

## Requirements
- R1: After reset the request output is 0, the cause is 0, the count is 0 and the configuration is all zero (timer off).
- R2: With timeout code 00 the count stays at 0 and no reset request is raised, whatever the enables and service writes.
- R3: The count rises by one on each cycle in which the enable chosen by the clock-select field is high (select 00 uses clkEn[0], the low-power clock; 01 uses clkEn[1], the internal reference; 10 uses clkEn[2], the external oscillator; 11 uses clkEn[3], the bus clock). The other three enables have no effect.
- R4: The request is raised on the enabled tick that would take the count past its limit. For the short class, codes 01, 10 and 11 give limits of 2^5, 2^8 and 2^10 ticks. For the long class they give 2^13, 2^16 and 2^18 ticks.
- R5: A write of 0x55 to the service register arms the key, and a following write of 0xAA clears the count. A write of any other value disarms the key, and a write of 0xAA without arming has no effect.
- R6: Once raised, the reset request stays high and the count stays frozen until rstN is asserted.
- R7: resetCause is 2'b01 after a timeout and 2'b10 after a window violation.
- R8: In stop mode with stop-enable 0, the count is cleared to 0 and held there. With stop-enable 1 it keeps counting.
- R9: In debug mode with debug-enable 0, the count is cleared to 0 and held there. With debug-enable 1 it keeps counting.
- R10: With windowed mode on, completing the key while the count is below three quarters of the limit raises the request at once with cause 2'b10. At or above that point the count clears normally.
- R11: Only the first control write after reset takes effect, and all later control writes are ignored.
- R12: The control byte fields are: bit 0 windowed mode, bit 1 long class, bits 3:2 timeout code, bit 4 stop-enable, bit 5 debug-enable, bits 7:6 clock select. A write with wrSel=0 addresses the control register and a write with wrSel=1 addresses the service register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkEn | input | 4 | Candidate count enables, indexed by clock-select code |
| stopMode | input | 1 | System is in a stop mode |
| debugMode | input | 1 | System is halted for debug |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | 0 selects the control register, 1 the service register |
| wrData | input | 8 | Write data |
| resetReq | output | 1 | System reset request, held once raised |
| resetCause | output | 2 | 01 timeout, 10 window violation |
| count | output | 18 | Current counter value, for debug |

## Verification
Several behaviours are checked by properties on every cycle. The request stays latched. A held mode or a disabled timer forces the count to zero. A locked configuration never changes. The count moves only by one step or by a clear, and a completed key outside windowed mode clears it. The exact expiry tick for each length, the three-quarter window boundary, key disarming by a stray byte, and which enable drives the count are shown only by the bench scenarios. In those scenarios a behavioural model is compared against the outputs cycle by cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Control byte, packed so that bit 7 is the MSB of the written byte
  typedef struct packed {
    logic [1:0] clkSel;
    logic       dbgEn;
    logic       stopEn;
    logic [1:0] code;
    logic       longSel;
    logic       winEn;
  } wdCfg_t;

  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic tick;
    logic hold;
    logic svcDone;
  } wdStrobe_t;

  localparam logic [7:0] SVC_ARM  = 8'h55;
  localparam logic [7:0] SVC_FIRE = 8'hAA;

  localparam logic [1:0] CAUSE_TIMEOUT = 2'b01;
  localparam logic [1:0] CAUSE_WINDOW  = 2'b10;

endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int N_SRC = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [N_SRC-1:0] clkEn,
  input  logic             stopMode,
  input  logic             debugMode,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [7:0]       wrData,
  output wdCfg_t           cfg,
  output logic             locked,
  output wdStrobe_t        strobe
);

  logic armed;
  logic ctrlWr;
  logic svcWr;
  logic srcTick;

  assign ctrlWr = wrEn && !wrSel;
  assign svcWr  = wrEn && wrSel;

  // Write-once configuration
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg    <= '0;
      locked <= 1'b0;
    end else if (ctrlWr && !locked) begin
      cfg    <= wdCfg_t'(wrData);
      locked <= 1'b1;
    end
  end

  // Two-byte service key: arm byte then fire byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
    end else if (svcWr) begin
      armed <= (wrData == SVC_ARM);
    end
  end

  assign srcTick = clkEn[cfg.clkSel];

  always_comb begin
    strobe.tick    = srcTick;
    strobe.hold    = (cfg.code == 2'b00)
                  || (stopMode  && !cfg.stopEn)
                  || (debugMode && !cfg.dbgEn);
    strobe.svcDone = svcWr && armed && (wrData == SVC_FIRE);
  end

endmodule

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int SHORT_EXP1 = 5,
  parameter int SHORT_EXP2 = 8,
  parameter int SHORT_EXP3 = 10,
  parameter int LONG_EXP1  = 13,
  parameter int LONG_EXP2  = 16,
  parameter int LONG_EXP3  = 18,
  parameter int CNT_W      = LONG_EXP3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       code,
  input  logic             longSel,
  input  logic             winEn,
  input  wdStrobe_t        strobe,
  output logic [CNT_W-1:0] count,
  output logic             resetReq,
  output logic [1:0]       resetCause
);

  int unsigned expSel;
  logic [31:0] limit32;
  logic [CNT_W-1:0] lastVal;
  logic [CNT_W-1:0] winStart;

  always_comb begin
    unique case ({longSel, code})
      3'b001:  expSel = SHORT_EXP1;
      3'b010:  expSel = SHORT_EXP2;
      3'b011:  expSel = SHORT_EXP3;
      3'b101:  expSel = LONG_EXP1;
      3'b110:  expSel = LONG_EXP2;
      3'b111:  expSel = LONG_EXP3;
      default: expSel = SHORT_EXP1;
    endcase
    limit32  = 32'd1 << expSel;
    lastVal  = CNT_W'(limit32 - 32'd1);
    winStart = CNT_W'(limit32 - (limit32 >> 2));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count      <= '0;
      resetReq   <= 1'b0;
      resetCause <= 2'b00;
    end else if (!resetReq) begin
      if (strobe.hold) begin
        count <= '0;
      end else if (strobe.svcDone) begin
        if (winEn && (count < winStart)) begin
          resetReq   <= 1'b1;
          resetCause <= CAUSE_WINDOW;
        end else begin
          count <= '0;
        end
      end else if (strobe.tick) begin
        if (count == lastVal) begin
          resetReq   <= 1'b1;
          resetCause <= CAUSE_TIMEOUT;
        end else begin
          count <= count + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int SHORT_EXP1 = 5,
  parameter int SHORT_EXP2 = 8,
  parameter int SHORT_EXP3 = 10,
  parameter int LONG_EXP1  = 13,
  parameter int LONG_EXP2  = 16,
  parameter int LONG_EXP3  = 18,
  parameter int N_SRC      = 4,
  localparam int CNT_W     = LONG_EXP3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [N_SRC-1:0] clkEn,
  input  logic             stopMode,
  input  logic             debugMode,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [7:0]       wrData,
  output logic             resetReq,
  output logic [1:0]       resetCause,
  output logic [CNT_W-1:0] count
);

  wdCfg_t    cfgQ;
  logic      cfgLocked;
  wdStrobe_t strobe;

  wdog_ctrl #(.N_SRC(N_SRC)) u_ctrl (
    .clk(clk), .rstN(rstN), .clkEn(clkEn),
    .stopMode(stopMode), .debugMode(debugMode),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .cfg(cfgQ), .locked(cfgLocked), .strobe(strobe)
  );

  wdog_dp #(
    .SHORT_EXP1(SHORT_EXP1), .SHORT_EXP2(SHORT_EXP2), .SHORT_EXP3(SHORT_EXP3),
    .LONG_EXP1(LONG_EXP1), .LONG_EXP2(LONG_EXP2), .LONG_EXP3(LONG_EXP3),
    .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .code(cfgQ.code), .longSel(cfgQ.longSel), .winEn(cfgQ.winEn),
    .strobe(strobe),
    .count(count), .resetReq(resetReq), .resetCause(resetCause)
  );

endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
  import wdog_pkg::*;
#(
  parameter int CNT_W = 18
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             wrSel,
  input logic             resetReq,
  input logic [1:0]       resetCause,
  input logic [CNT_W-1:0] count,
  input wdCfg_t           cfg,
  input logic             locked,
  input wdStrobe_t        strobe
);

  // R6
  req_latched_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> (resetReq && $stable(count) && $stable(resetCause)));

  // R7
  cause_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(resetCause) && (resetReq == (resetCause != 2'b00)));

  // R2
  disabled_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.code == 2'b00 && !resetReq) |=> (count == '0 && !resetReq));

  // R8 R9
  hold_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.hold && !resetReq) |=> (count == '0));

  // R11
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (locked && wrEn && !wrSel) |=> ($stable(cfg) && locked));

  // R3
  step_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    !resetReq |=> (count == $past(count) || count == $past(count) + 1'b1 || count == '0));

  // R5
  key_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.svcDone && !cfg.winEn && !strobe.hold && !resetReq) |=> (count == '0 && !resetReq));

endmodule

bind wdog_core wdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel),
  .resetReq(resetReq), .resetCause(resetCause), .count(count),
  .cfg(cfgQ), .locked(cfgLocked), .strobe(strobe)
);

// File: tb/test_wdog_core.sv
`timescale 1ns/1ps
module test_wdog_core;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  clkEn = '0;
  logic        stopMode = 1'b0;
  logic        debugMode = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrSel = 1'b0;
  logic [7:0]  wrData = '0;
  logic        resetReq;
  logic [1:0]  resetCause;
  logic [17:0] count;

  int nChecks = 0;
  int nFails  = 0;
  bit cmpOn   = 1'b0;
  bit done    = 1'b0;

  // behavioural reference state
  int mWin, mLong, mCode, mStop, mDbg, mSel, mLocked, mArmed, mCnt, mReq, mCause;

  always #5 clk = ~clk;

  wdog_core i_wdog_core (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .stopMode(stopMode),
    .debugMode(debugMode), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .resetReq(resetReq), .resetCause(resetCause), .count(count)
  );

  function automatic int limitOf(int lng, int c);
    int e;
    if (lng != 0) e = (c == 1) ? 13 : (c == 2) ? 16 : 18;
    else          e = (c == 1) ? 5  : (c == 2) ? 8  : 10;
    return 1 << e;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mWin = 0; mLong = 0; mCode = 0; mStop = 0; mDbg = 0; mSel = 0;
      mLocked = 0; mArmed = 0; mCnt = 0; mReq = 0; mCause = 0;
    end else begin
      int lim;
      bit svc, hold, tick;
      svc  = 0;
      hold = (mCode == 0) || (stopMode && mStop == 0) || (debugMode && mDbg == 0);
      tick = clkEn[mSel];
      lim  = limitOf(mLong, mCode);
      if (wrEn && wrSel) begin
        if (wrData == 8'hAA && mArmed != 0) svc = 1;
        mArmed = (wrData == 8'h55) ? 1 : 0;
      end
      if (mReq == 0) begin
        if (hold) mCnt = 0;
        else if (svc) begin
          if (mWin != 0 && mCnt < (lim * 3) / 4) begin mReq = 1; mCause = 2; end
          else mCnt = 0;
        end else if (tick) begin
          if (mCnt == lim - 1) begin mReq = 1; mCause = 1; end
          else mCnt = mCnt + 1;
        end
      end
      if (wrEn && !wrSel && mLocked == 0) begin
        mWin = wrData[0]; mLong = wrData[1]; mCode = wrData[3:2];
        mStop = wrData[4]; mDbg = wrData[5]; mSel = wrData[7:6]; mLocked = 1;
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (cmpOn && !done) begin
      check("R3 model count", int'(count), mCnt);
      check("R6 model resetReq", int'(resetReq), mReq);
      check("R7 model resetCause", int'(resetCause), mCause);
    end
  end

  task automatic doReset();
    cmpOn = 0;
    rstN = 0; clkEn = '0; stopMode = 0; debugMode = 0; wrEn = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    cmpOn = 1;
  endtask

  task automatic wr(bit sel, logic [7:0] d);
    wrEn = 1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic run(int n, logic [3:0] en);
    clkEn = en;
    repeat (n) @(negedge clk);
    clkEn = '0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset();
    // R1 reset state
    check("R1 count", int'(count), 0);
    check("R1 resetReq", int'(resetReq), 0);
    check("R1 cause", int'(resetCause), 0);

    // R2 timer off: enables and key have no effect
    run(40, 4'b1111);
    check("R2 count stays zero", int'(count), 0);
    wr(1, 8'h55); wr(1, 8'hAA);
    check("R2 no request", int'(resetReq), 0);

    // R12 0xC4: bus clock select 11, short class, code 01
    wr(0, 8'hC4);
    run(10, 4'b1000);
    check("R3 bus ticks", int'(count), 10);
    run(5, 4'b0111);
    check("R3 other enables ignored", int'(count), 10);
    wr(0, 8'h00);
    run(3, 4'b1000);
    check("R11 second write ignored", int'(count), 13);
    wr(1, 8'h55); wr(1, 8'hAA);
    check("R5 key clears", int'(count), 0);
    run(6, 4'b1000);
    wr(1, 8'h55); wr(1, 8'h12); wr(1, 8'hAA);
    check("R5 stray byte disarms", int'(count), 6);
    run(25, 4'b1000);
    check("R4 short 2^5 not yet", int'(resetReq), 0);
    check("R4 count at last value", int'(count), 31);
    run(1, 4'b1000);
    check("R4 short 2^5 expiry", int'(resetReq), 1);
    check("R7 timeout cause", int'(resetCause), 1);
    run(20, 4'b1111);
    wr(1, 8'h55); wr(1, 8'hAA);
    check("R6 request held", int'(resetReq), 1);
    check("R6 count frozen", int'(count), 31);

    // R8 stop mode, R12 low-power select 00, code 11
    doReset();
    wr(0, 8'h0C);
    run(50, 4'b0001);
    check("R8 counting", int'(count), 50);
    stopMode = 1;
    run(1, 4'b0001);
    check("R8 stop clears", int'(count), 0);
    run(5, 4'b0001);
    check("R8 stop holds", int'(count), 0);
    stopMode = 0;
    run(4, 4'b0001);
    check("R8 resumes", int'(count), 4);
    doReset();
    wr(0, 8'h1C);
    run(7, 4'b0001);
    stopMode = 1;
    run(3, 4'b0001);
    stopMode = 0;
    check("R8 stop-enable counts on", int'(count), 10);

    // R9 debug mode, internal reference select 01
    doReset();
    wr(0, 8'h4C);
    run(9, 4'b0010);
    debugMode = 1;
    run(1, 4'b0010);
    debugMode = 0;
    check("R9 debug clears", int'(count), 0);
    doReset();
    wr(0, 8'h6C);
    run(9, 4'b0010);
    debugMode = 1;
    run(3, 4'b0010);
    debugMode = 0;
    check("R9 debug-enable counts on", int'(count), 12);

    // R10 window, oscillator select 10, short code 10 (limit 256, open at 192)
    doReset();
    wr(0, 8'h89);
    run(100, 4'b0100);
    wr(1, 8'h55); wr(1, 8'hAA);
    check("R10 early key request", int'(resetReq), 1);
    check("R10 early key cause", int'(resetCause), 2);
    doReset();
    wr(0, 8'h89);
    run(192, 4'b0100);
    wr(1, 8'h55); wr(1, 8'hAA);
    check("R10 key at boundary clears", int'(count), 0);
    check("R10 no request at boundary", int'(resetReq), 0);
    run(191, 4'b0100);
    wr(1, 8'h55); wr(1, 8'hAA);
    check("R10 key just below boundary", int'(resetReq), 1);

    // R4 long class codes 01 and 10
    doReset();
    wr(0, 8'hC6);
    run(8191, 4'b1000);
    check("R4 long 2^13 not yet", int'(resetReq), 0);
    run(1, 4'b1000);
    check("R4 long 2^13 expiry", int'(resetReq), 1);
    doReset();
    wr(0, 8'hCA);
    run(65535, 4'b1000);
    check("R4 long 2^16 not yet", int'(resetReq), 0);
    run(1, 4'b1000);
    check("R4 long 2^16 expiry", int'(resetReq), 1);

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule